// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of peripheral request lines, remembers each new request as a pending bit, and offers the most urgent pending, enabled request to a processor as a vector number. Every line carries a two-bit urgency level, where 0 is the most urgent. A level mask holds back requests whose level is not more urgent than the programmed value. A request only interrupts service already in progress when its level is strictly more urgent than the level being serviced. Software can raise any line through a register write.

The processor takes a vector with `vec_ack`. That clears the line's pending bit and makes the vector's level the active level. The previous active level is saved on a small stack, and `eoi` restores it when the handler finishes. Separately, any one of the request lines can be chosen to drive a non-maskable output. That output ignores enables, mask and active level.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset:
  - `vec_valid` and `nmi_out` are 0.
  - All enables, pending bits and levels read 0.
  - The mask (address 4) reads 4, so nothing is masked.
  - The active level (address 6, bits [2:0]) reads 4, meaning idle.
- R2: Pending is set only by a rising edge of `irq_in[i]`. A line held high does not become pending again after its acknowledge until it falls and rises again. Pending bits read at address 1.
- R3: A pending line whose enable bit is 0 is never presented. Enable bits are at address 0, bit i for line i. Once the bit is set, the line is presented.
- R4: Among the candidates, the lowest level value wins. On equal levels, the lowest line number wins. Levels are held at address 2 for lines 0–15 and address 3 for lines 16–31, with line i at bits [2(i mod 16)+1 : 2(i mod 16)].
- R5: A line whose level is greater than or equal to the mask value (address 4, bits [2:0]) is held off. When the mask is raised, the line is presented.
- R6: Writing a 1 to bit i of address 1 sets line i pending.
- R7: Once `vec_valid` rises, `vec_valid` and `vec_id` stay constant until `vec_ack`, even if a more urgent request arrives.
- R8: `vec_ack` clears the vector's pending bit and makes its level the active level. A later request is presented only if its level is strictly below the active level.
- R9: `eoi` restores the active level that was in force before the most recent acknowledge. An `eoi` with nothing active has no effect.
- R10: When the select enable (address 5, bit 8) is set, `nmi_out` follows the line `irq_in[sel]` one cycle later, where sel is address 5, bits [4:0]. The output is independent of line enable, mask and active level. It is 0 when the select enable is clear.
- R11: All registers read back what was written. Address 6 is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Peripheral request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| vec_valid | output | 1 | A vector is being offered |
| vec_id | output | 5 | Offered line number |
| vec_ack | input | 1 | Processor takes the offered vector |
| eoi | input | 1 | End of service of the active handler |
| nmi_out | output | 1 | Non-maskable request output |

## Verification
The bench builds the controller with its default parameters: 32 lines, two-bit levels, a four-entry level stack and 32-bit registers. These values put the two-word level map and the 5-bit line select within reach. The stack gets the deepest nesting the level count allows. Under this configuration the directed scenarios cover several things:
- same-level ties;
- a more urgent request arriving while a vector waits;
- a mask boundary exactly equal to a line's level;
- nested pre-emption unwinding through two `eoi` pulses.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_IRQ = 32,
  parameter int LVL_W   = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         irq_in,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic                       vec_valid,
  output logic [$clog2(NUM_IRQ)-1:0] vec_id,
  input  logic                       vec_ack,
  input  logic                       eoi,
  output logic                       nmi_out
);
  localparam int IDW       = $clog2(NUM_IRQ);
  localparam int NUM_LVL   = 1 << LVL_W;
  localparam int STK_D     = NUM_LVL;
  localparam int STK_IW    = $clog2(STK_D);
  localparam int SPW       = $clog2(STK_D + 1);
  localparam int PRIO_BITS = NUM_IRQ * LVL_W;
  localparam int PRIO_WDS  = PRIO_BITS / DATA_W;
  localparam int A_EN      = 0;
  localparam int A_PEND    = 1;
  localparam int A_PRIO    = 2;
  localparam int A_MASK    = A_PRIO + PRIO_WDS;
  localparam int A_NMI     = A_MASK + 1;
  localparam int A_ACT     = A_NMI + 1;
  localparam int NMI_EN_B  = 8;

  logic [NUM_IRQ-1:0]   irq_q, pending, enable, set_vec, clr_vec, cand;
  logic [PRIO_BITS-1:0] prio;
  logic [LVL_W:0]       mask, act_lvl, vec_lvl, best_lvl;
  logic [IDW-1:0]       nmi_sel, best_id;
  logic                 nmi_en, best_found;
  logic [LVL_W:0]       stk [STK_D];
  logic [SPW-1:0]       sp;

  wire wr_en   = reg_wr && reg_addr == ADDR_W'(A_EN);
  wire wr_pend = reg_wr && reg_addr == ADDR_W'(A_PEND);
  wire wr_mask = reg_wr && reg_addr == ADDR_W'(A_MASK);
  wire wr_nmi  = reg_wr && reg_addr == ADDR_W'(A_NMI);
  wire take    = vec_valid && vec_ack;
  wire pop     = eoi && !take && sp != '0;

  assign set_vec = (irq_in & ~irq_q) | (wr_pend ? reg_wdata[NUM_IRQ-1:0] : '0);
  assign clr_vec = take ? (NUM_IRQ'(1) << vec_id) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= '0;
      pending <= '0;
      enable  <= '0;
    end else begin
      irq_q   <= irq_in;
      pending <= (pending & ~clr_vec) | set_vec;
      if (wr_en) enable <= reg_wdata[NUM_IRQ-1:0];
    end
  end

  for (genvar w = 0; w < PRIO_WDS; w++) begin : g_prio
    always_ff @(posedge clk) begin
      if (!rst_n) prio[w*DATA_W +: DATA_W] <= '0;
      else if (reg_wr && reg_addr == ADDR_W'(A_PRIO + w))
        prio[w*DATA_W +: DATA_W] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask    <= (LVL_W+1)'(NUM_LVL);
      nmi_sel <= '0;
      nmi_en  <= 1'b0;
      nmi_out <= 1'b0;
    end else begin
      if (wr_mask) mask <= reg_wdata[LVL_W:0];
      if (wr_nmi) begin
        nmi_sel <= reg_wdata[IDW-1:0];
        nmi_en  <= reg_wdata[NMI_EN_B];
      end
      nmi_out <= nmi_en && irq_in[nmi_sel];
    end
  end

  always_comb begin
    best_found = 1'b0;
    best_id    = '0;
    best_lvl   = (LVL_W+1)'(NUM_LVL);
    for (int i = 0; i < NUM_IRQ; i++) begin
      cand[i] = pending[i] && enable[i] &&
                {1'b0, prio[i*LVL_W +: LVL_W]} < mask &&
                {1'b0, prio[i*LVL_W +: LVL_W]} < act_lvl;
      if (cand[i] && {1'b0, prio[i*LVL_W +: LVL_W]} < best_lvl) begin
        best_found = 1'b1;
        best_id    = IDW'(i);
        best_lvl   = {1'b0, prio[i*LVL_W +: LVL_W]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_id    <= '0;
      vec_lvl   <= '0;
    end else if (take) begin
      vec_valid <= 1'b0;
    end else if (!vec_valid && best_found) begin
      vec_valid <= 1'b1;
      vec_id    <= best_id;
      vec_lvl   <= best_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_lvl <= (LVL_W+1)'(NUM_LVL);
      sp      <= '0;
      for (int k = 0; k < STK_D; k++) stk[k] <= '0;
    end else if (take) begin
      stk[STK_IW'(sp)] <= act_lvl;
      sp               <= sp + 1'b1;
      act_lvl          <= vec_lvl;
    end else if (pop) begin
      act_lvl <= stk[STK_IW'(sp - 1'b1)];
      sp      <= sp - 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_EN))   reg_rdata = DATA_W'(enable);
    if (reg_addr == ADDR_W'(A_PEND)) reg_rdata = DATA_W'(pending);
    if (reg_addr == ADDR_W'(A_MASK)) reg_rdata = DATA_W'(mask);
    if (reg_addr == ADDR_W'(A_ACT))  reg_rdata = DATA_W'(act_lvl);
    if (reg_addr == ADDR_W'(A_NMI)) begin
      reg_rdata[IDW-1:0]  = nmi_sel;
      reg_rdata[NMI_EN_B] = nmi_en;
    end
    for (int w = 0; w < PRIO_WDS; w++)
      if (reg_addr == ADDR_W'(A_PRIO + w)) reg_rdata = prio[w*DATA_W +: DATA_W];
  end

  p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ack |=> vec_valid && $stable(vec_id));

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && !set_vec[vec_id] |=> !pending[$past(vec_id)]);

  p_vec_urgent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec_lvl < act_lvl);

  p_stack_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(STK_D));

  p_eoi_restores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take && !eoi |=> $stable(act_lvl));

  p_nmi_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out |-> $past(nmi_en) && $past(irq_in != '0));

  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid && enable == '0 |=> !vec_valid);
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        vec_valid;
  logic [4:0]  vec_id;
  logic        vec_ack = 1'b0;
  logic        eoi = 1'b0;
  logic        nmi_out;

  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vec_valid(vec_valid), .vec_id(vec_id), .vec_ack(vec_ack),
    .eoi(eoi), .nmi_out(nmi_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ack();
    vec_ack = 1'b1; step(); vec_ack = 1'b0;
  endtask

  task automatic end_isr();
    eoi = 1'b1; step(); eoi = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 vec_valid", 32'(vec_valid), 0);
    chk("R1 nmi_out", 32'(nmi_out), 0);
    rd(0, d); chk("R1 enable", d, 0);
    rd(1, d); chk("R1 pending", d, 0);
    rd(2, d); chk("R1 levels", d, 0);
    rd(4, d); chk("R1 mask", d, 4);
    rd(6, d); chk("R1 active idle", d, 4);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    irq_in[5] = 1'b1;
    step(3);
    rd(1, d); chk("R2 pending on rise", d, 32'h20);
    chk("R3 disabled not offered", 32'(vec_valid), 0);
    wr(0, 32'h20);
    step();
    chk("R3 offered after enable", 32'(vec_valid), 1);
    chk("R3 vec id", 32'(vec_id), 5);
    ack();
    rd(1, d); chk("R8 pending cleared", d, 0);
    rd(6, d); chk("R8 active level", d, 0);
    step(3);
    rd(1, d); chk("R2 held high no re-pend", d, 0);
    end_isr();
    rd(6, d); chk("R9 back to idle", d, 4);
    step(2);
    chk("R2 nothing offered", 32'(vec_valid), 0);
    irq_in[5] = 1'b0;
    wr(0, 32'h0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(2, (32'd2 << 6) | (32'd1 << 14) | (32'd1 << 18));
    rd(2, d); chk("R11 level readback", d, 32'h0004_4080);
    wr(0, 32'h288);
    wr(1, 32'h288);
    rd(1, d); chk("R6 software set", d, 32'h288);
    step();
    chk("R4 lowest level wins", 32'(vec_id), 7);
    ack();
    step(2);
    chk("R8 equal level no preempt", 32'(vec_valid), 0);
    end_isr();
    step();
    chk("R4 tie lowest index", 32'(vec_valid), 1);
    chk("R4 tie id", 32'(vec_id), 9);
    ack(); end_isr();
    step();
    chk("R4 last candidate", 32'(vec_id), 3);
    ack();
    rd(6, d); chk("R8 active level 2", d, 2);
    wr(1, 32'h80);
    step();
    chk("R8 preempt when more urgent", 32'(vec_valid), 1);
    chk("R8 preempt id", 32'(vec_id), 7);
    ack();
    rd(6, d); chk("R8 nested level", d, 1);
    end_isr();
    rd(6, d); chk("R9 restore level 2", d, 2);
    end_isr();
    rd(6, d); chk("R9 restore idle", d, 4);
    end_isr();
    rd(6, d); chk("R9 eoi when idle ignored", d, 4);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(4, 32'd2);
    wr(1, 32'h8);
    step(2);
    chk("R5 level equal to mask held", 32'(vec_valid), 0);
    wr(1, 32'h80);
    step();
    chk("R5 below mask offered", 32'(vec_id), 7);
    ack(); end_isr();
    wr(4, 32'd4);
    step();
    chk("R5 raised mask releases", 32'(vec_valid), 1);
    chk("R5 released id", 32'(vec_id), 3);
    ack(); end_isr();
  endtask

  task automatic t_stable();
    wr(1, 32'h8);
    step();
    chk("R7 first vector", 32'(vec_id), 3);
    wr(1, 32'h80);
    step(2);
    chk("R7 still valid", 32'(vec_valid), 1);
    chk("R7 id unchanged", 32'(vec_id), 3);
    ack();
    step();
    chk("R7 next after ack", 32'(vec_id), 7);
    ack(); end_isr(); end_isr();
  endtask

  task automatic t_nmi();
    logic [31:0] d;
    wr(0, 32'h0);
    wr(4, 32'd0);
    wr(5, 32'h10C);
    rd(5, d); chk("R11 select readback", d, 32'h10C);
    irq_in[12] = 1'b1;
    step();
    chk("R10 nmi follows line", 32'(nmi_out), 1);
    chk("R10 no vector", 32'(vec_valid), 0);
    irq_in[12] = 1'b0;
    step();
    chk("R10 nmi falls", 32'(nmi_out), 0);
    wr(5, 32'h10D);
    irq_in[12] = 1'b1;
    step(2);
    chk("R10 other line ignored", 32'(nmi_out), 0);
    wr(5, 32'h00C);
    step(2);
    chk("R10 disabled select", 32'(nmi_out), 0);
    wr(6, 32'h0);
    rd(6, d); chk("R11 active read-only", d, 4);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_edge();
    t_prio();
    t_mask();
    t_stable();
    t_nmi();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule